// File: doc/BRIEF.md
# Selectable-Clock Baud Rate Timer

This block produces the bit-rate timing for an asynchronous serial port. It contains an 8-bit timer that reloads itself automatically, plus a short divider that follows the timer. The timer advances on one of three count enables: the oscillator rate divided by twelve, the system clock divided by four, or every system clock. The system clock is the oscillator multiplied by one, two or four. That ratio is an input of the block, and from it the block derives the oscillator-rate enable internally. Each time the timer overflows, it emits a one-cycle pulse. That pulse is then divided by two, or passed through directly when the doubling input is set, to give a tick at sixteen times the bit rate.

Software-facing logic sets the select bits, the reload value, the doubling bit and the run bit as static inputs. A receiver or transmitter consumes `baud_tick` as its oversampling strobe.

Top module: `baud_timer_top`

## Requirements
- R1: With `sel_mid`=0 and `sel_fast`=0, the timer advances once every twelve oscillator periods, that is, every 12×ratio system cycles. The multiplier setting therefore leaves the rate unchanged in oscillator time.
- R2: With `sel_mid`=1 and `sel_fast`=0, the timer advances once every four system cycles.
- R3: With `sel_fast`=1, the timer advances on every system cycle, whatever the value of `sel_mid`.
- R4: When the timer advances from FFh, it loads `reload` and raises `ovf_pulse` for one cycle. In steady state, overflows are therefore (256−`reload`) advances apart, and with `reload`=FFh every advance overflows.
- R5: `mult_mode` sets the system-to-oscillator ratio: 00 gives 1, 01 gives 2, and 10 or 11 gives 4.
- R6: `baud_tick` is high for the cycle after every second overflow when `dbl`=0, and for the cycle after every overflow when `dbl`=1.
- R7: While `run`=0 the timer holds its value and no overflow occurs. On resuming, it continues from the held value.
- R8: Reset clears the timer, the prescalers and both outputs. After release with `run`=1 and `sel_fast`=1, the first overflow is seen 256 cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Timer run enable |
| mult_mode | input | 2 | System-to-oscillator ratio code |
| sel_mid | input | 1 | Count at system clock / 4 |
| sel_fast | input | 1 | Count at every system clock (has priority) |
| reload | input | 8 | Auto-reload value |
| dbl | input | 1 | Doubling bit: baud tick per overflow |
| ovf_pulse | output | 1 | One-cycle timer overflow pulse |
| baud_tick | output | 1 | Tick at sixteen times the bit rate |

## Verification
The hardest case to reach is the slow source combined with a multiplier change. In that case the rate is set by the internal oscillator-phase counter, which is invisible at the ports. The stimulus switches `mult_mode` while the slow source is selected and discards the first two overflow intervals so that the phase and the prescaler settle. It then compares the next interval against 12×ratio×(256−reload). Freezing is driven mid-period at a known offset from an observed overflow, so that any loss of the held count shows up as a shortened gap.

// File: rtl/baud_timer_pkg.sv
package baud_timer_pkg;
   typedef enum logic [1:0] {
      MUL_1X = 2'b00,
      MUL_2X = 2'b01,
      MUL_4X = 2'b10,
      MUL_4B = 2'b11
   } mult_e;

   // ratio minus one, system cycles per oscillator period
   function automatic logic [1:0] ratio_m1(input logic [1:0] code);
      case (code)
         2'b00:   ratio_m1 = 2'd0;
         2'b01:   ratio_m1 = 2'd1;
         default: ratio_m1 = 2'd3;
      endcase
   endfunction
endpackage

// File: rtl/osc_phase_gen.sv
module osc_phase_gen
   import baud_timer_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mult_mode,
   output logic       osc_ce
);
   logic [1:0] phase_q;
   logic [1:0] last_idx;

   assign last_idx = ratio_m1(mult_mode);
   assign osc_ce   = (phase_q >= last_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      phase_q <= '0;
      else if (osc_ce) phase_q <= '0;
      else             phase_q <= phase_q + 2'd1;
   end

   AST_OSC_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      (mult_mode != 2'b00 && osc_ce) |=> (!osc_ce || $past(mult_mode) != mult_mode)); // R5
endmodule

// File: rtl/count_prescaler.sv
module count_prescaler #(
   parameter int SLOW_DIV = 12,
   parameter int MID_DIV  = 4
)(
   input  logic clk,
   input  logic rst_n,
   input  logic osc_ce,
   output logic slow_ce,
   output logic mid_ce
);
   localparam int SW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

   logic [SW-1:0] slow_q;
   assign slow_ce = osc_ce && (slow_q == SW'(SLOW_DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slow_q <= '0;
      else if (slow_ce) slow_q <= '0;
      else if (osc_ce)  slow_q <= slow_q + 1'b1;
   end

   generate
      if (MID_DIV == 1) begin : g_mid_pass
         assign mid_ce = 1'b1;
      end else begin : g_mid_cnt
         localparam int MW = $clog2(MID_DIV);
         logic [MW-1:0] mid_q;
         assign mid_ce = (mid_q == MW'(MID_DIV - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      mid_q <= '0;
            else if (mid_ce) mid_q <= '0;
            else             mid_q <= mid_q + 1'b1;
         end
         AST_MID_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
            mid_ce |=> !mid_ce); // R2
      end
   endgenerate

   AST_SLOW_ON_OSC: assert property (@(posedge clk) disable iff (!rst_n)
      slow_ce |-> osc_ce); // R1
   AST_SLOW_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      slow_ce |=> !slow_ce); // R1
endmodule

// File: rtl/reload_timer.sv
module reload_timer #(
   parameter int TMR_W = 8
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             count_ce,
   input  logic [TMR_W-1:0] reload,
   output logic             ovf_pulse
);
   localparam logic [TMR_W-1:0] TOP = '1;

   logic [TMR_W-1:0] tmr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmr_q     <= '0;
         ovf_pulse <= 1'b0;
      end else begin
         ovf_pulse <= 1'b0;
         if (count_ce) begin
            if (tmr_q == TOP) begin
               tmr_q     <= reload;
               ovf_pulse <= 1'b1;
            end else begin
               tmr_q <= tmr_q + 1'b1;
            end
         end
      end
   end

   AST_RELOAD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (count_ce && tmr_q == TOP) |=> (tmr_q == $past(reload))); // R4
   AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse |-> $past(count_ce)); // R4
   AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !count_ce |=> ($stable(tmr_q) && !ovf_pulse)); // R7
endmodule

// File: rtl/baud_tick_div.sv
module baud_tick_div (
   input  logic clk,
   input  logic rst_n,
   input  logic ovf_in,
   input  logic dbl,
   output logic baud_tick
);
   logic half_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_q    <= 1'b0;
         baud_tick <= 1'b0;
      end else begin
         baud_tick <= 1'b0;
         if (ovf_in) begin
            if (dbl) begin
               baud_tick <= 1'b1;
            end else begin
               baud_tick <= half_q;
               half_q    <= ~half_q;
            end
         end
      end
   end

   AST_TICK_NEEDS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      baud_tick |-> $past(ovf_in)); // R6
   AST_DBL_EVERY_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_in && dbl) |=> baud_tick); // R6
endmodule

// File: rtl/baud_timer_top.sv
module baud_timer_top #(
   parameter int TMR_W    = 8,
   parameter int SLOW_DIV = 12,
   parameter int MID_DIV  = 4
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [1:0]       mult_mode,
   input  logic             sel_mid,
   input  logic             sel_fast,
   input  logic [TMR_W-1:0] reload,
   input  logic             dbl,
   output logic             ovf_pulse,
   output logic             baud_tick
);
   generate
      if (TMR_W < 2) begin : g_bad_width
         $error("TMR_W must be at least 2");
      end
      if (SLOW_DIV < 2) begin : g_bad_slow
         $error("SLOW_DIV must be at least 2");
      end
      if (MID_DIV < 1) begin : g_bad_mid
         $error("MID_DIV must be at least 1");
      end
   endgenerate

   logic osc_ce, slow_ce, mid_ce, src_ce, count_ce;

   osc_phase_gen u_phase (
      .clk(clk), .rst_n(rst_n), .mult_mode(mult_mode), .osc_ce(osc_ce)
   );

   count_prescaler #(.SLOW_DIV(SLOW_DIV), .MID_DIV(MID_DIV)) u_pre (
      .clk(clk), .rst_n(rst_n), .osc_ce(osc_ce),
      .slow_ce(slow_ce), .mid_ce(mid_ce)
   );

   // fastest select wins over the divide-by-four select
   always_comb begin
      if (sel_fast)     src_ce = 1'b1;
      else if (sel_mid) src_ce = mid_ce;
      else              src_ce = slow_ce;
   end
   assign count_ce = run & src_ce;

   reload_timer #(.TMR_W(TMR_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .count_ce(count_ce),
      .reload(reload), .ovf_pulse(ovf_pulse)
   );

   baud_tick_div u_div (
      .clk(clk), .rst_n(rst_n), .ovf_in(ovf_pulse),
      .dbl(dbl), .baud_tick(baud_tick)
   );

   AST_STOP_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !ovf_pulse); // R7
endmodule

// File: tb/tb_baud_timer_top.sv
module tb_baud_timer_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       run = 1'b0;
   logic [1:0] mult_mode = 2'b00;
   logic       sel_mid = 1'b0;
   logic       sel_fast = 1'b0;
   logic [7:0] reload = 8'h00;
   logic       dbl = 1'b0;
   logic       ovf_pulse, baud_tick;

   int n_tests = 0;
   int n_fail  = 0;
   int cycles  = 0;
   bit done    = 0;

   always #10 clk = ~clk;

   baud_timer_top dut (
      .clk(clk), .rst_n(rst_n), .run(run), .mult_mode(mult_mode),
      .sel_mid(sel_mid), .sel_fast(sel_fast), .reload(reload),
      .dbl(dbl), .ovf_pulse(ovf_pulse), .baud_tick(baud_tick)
   );

   always @(posedge clk) cycles <= cycles + 1;

   function automatic int ratio(input logic [1:0] m);
      return (m == 2'b00) ? 1 : (m == 2'b01) ? 2 : 4;
   endfunction

   function automatic int exp_ovf_gap(input logic f, input logic md,
                                      input logic [1:0] m, input logic [7:0] r);
      int div;
      div = f ? 1 : md ? 4 : 12 * ratio(m);
      return (256 - int'(r)) * div;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // negedges until the selected output is seen high
   task automatic wait_hi(input bit use_tick, output int gap);
      gap = 0;
      do begin
         @(negedge clk);
         gap++;
      end while (!(use_tick ? baud_tick : ovf_pulse) && gap < 60000);
   endtask

   task automatic steady_gap(input bit use_tick, output int gap);
      int g;
      wait_hi(use_tick, g);
      wait_hi(use_tick, g);
      wait_hi(use_tick, gap);
   endtask

   task automatic run_case(input string req, input logic f, input logic md,
                           input logic [1:0] m, input logic [7:0] r, input logic d);
      int g, e;
      @(negedge clk);
      sel_fast = f; sel_mid = md; mult_mode = m; reload = r; dbl = d; run = 1'b1;
      e = exp_ovf_gap(f, md, m, r);
      steady_gap(1'b0, g);
      check({req, " R4 overflow spacing"}, g, e);
      steady_gap(1'b1, g);
      check("R6 baud tick spacing", g, d ? e : 2 * e);
   endtask

   initial begin
      int g, sum;
      bit seen;
      void'($urandom(32'd4242));

      // R8: outputs low while in reset
      repeat (3) @(negedge clk);
      check("R8 ovf in reset", int'(ovf_pulse), 0);
      check("R8 tick in reset", int'(baud_tick), 0);

      // R8: first overflow 256 cycles after release
      sel_fast = 1'b1; reload = 8'h80; run = 1'b1;
      rst_n = 1'b1;
      wait_hi(1'b0, g);
      check("R8 first overflow from cleared timer", g, 256);

      // directed corners
      run_case("R3 fast", 1'b1, 1'b0, 2'b00, 8'hFF, 1'b0);  // overflow every cycle
      run_case("R3 fast overrides mid", 1'b1, 1'b1, 2'b10, 8'hF0, 1'b1);
      run_case("R2 mid", 1'b0, 1'b1, 2'b01, 8'hFD, 1'b0);
      run_case("R1 R5 slow 1X", 1'b0, 1'b0, 2'b00, 8'hF8, 1'b1);
      run_case("R1 R5 slow 2X", 1'b0, 1'b0, 2'b01, 8'hF8, 1'b1);
      run_case("R1 R5 slow 4X code 11", 1'b0, 1'b0, 2'b11, 8'hFC, 1'b0);

      // R7: freeze mid-period, value kept
      run_case("R7 setup", 1'b1, 1'b0, 2'b00, 8'h00, 1'b1);
      wait_hi(1'b0, g);
      repeat (100) @(negedge clk);
      run = 1'b0;
      seen = 0;
      for (int i = 0; i < 500; i++) begin
         @(negedge clk);
         if (ovf_pulse) seen = 1;
      end
      check("R7 no overflow while stopped", int'(seen), 0);
      run = 1'b1;
      wait_hi(1'b0, g);
      sum = 100 + 500 + g;
      check("R7 held count resumes", sum, 256 + 500);

      // constrained random
      for (int k = 0; k < 12; k++) begin
         logic [1:0] m, sel;
         logic [7:0] r;
         logic d;
         m   = 2'($urandom % 4);
         sel = 2'($urandom % 4);
         d   = 1'($urandom % 2);
         r   = 8'($urandom % 256);
         if (sel == 2'b00) r = r | 8'hE0;
         if (sel[1])      run_case("R3 random", 1'b1, sel[0], m, r, d);
         else if (sel[0]) run_case("R2 random", 1'b0, 1'b1, m, r, d);
         else             run_case("R1 random", 1'b0, 1'b0, m, r, d);
      end

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      wait (cycles > 190000);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule